// File: doc/BRIEF.md
# Flash Status Read Holding Latch

This block is the status-read path of a flash-style memory that is split into partitions. Each partition's write state machine supplies a live 8-bit status word. The host reads status using the active-low chip-enable and output-enable strobes, and an address field selects the partition. All inputs are taken as already synchronous to the block clock.

A read cycle begins when both strobes are low and at least one of them was high in the cycle before. That is the moment the later of the two falling strobes arrives. At that point the block copies the selected partition's live status into a holding register. It then presents the held value on the low byte of a 16-bit data bus for the rest of the cycle. Changes to the live status during the read therefore cannot tear the returned value. The host polls by running repeated read cycles, and each new cycle loads a fresh copy.

A status-mode input comes from the command decoder outside this block. It is high while reads are meant to return status, and only then is the bus driven.

Top module: `flash_status_latch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `dq_oe` is 0 and `dq_out` is 16'h0000.
- R2: `dq_oe` is 1 in the cycle after a clock edge at which both `ce_n` and `oe_n` were sampled low, provided `stat_mode` is 1. It is 0 in the cycle after an edge at which either strobe was sampled high.
- R3: At the first clock edge at which both strobes are sampled low, the held value is loaded. It comes from `status_live[7:0]` when `part_sel` is 0 and from `status_live[15:8]` when `part_sel` is 1. After that edge, `dq_out[7:0]` shows the held value.
- R4: While the strobes stay low, `dq_out` keeps the held value even if `status_live` or `part_sel` changes.
- R5: `dq_out[15:8]` is always 0.
- R6: If one strobe falls several cycles before the other, the held value is the status present when the second strobe falls. It is not the status present at the first fall.
- R7: Raising either strobe and lowering both again starts a new read cycle, which reloads the held value. This lets the host poll the ready flag in bit 7 until it reads 1.
- R8: When `stat_mode` is 0, `dq_oe` is 0 and `dq_out` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| part_sel | input | 1 | Partition select address bit |
| status_live | input | 16 | Live status words; partition p occupies bits [8p+7:8p] |
| stat_mode | input | 1 | High while reads return status |
| dq_out | output | 16 | Data bus value; status in the low byte |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Two events can land on the same clock edge: loading the held value at the start of a read cycle, and a change in the live status word or partition select. The bench provokes this by changing `status_live` and `part_sel` on the very cycle in which the second strobe falls. It also changes them again in the cycles that follow. A reference model computes the expected result: the value seen at the loading edge must be returned, and later changes must be ignored until the next read cycle begins.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int unsigned FSR_STAT_W = 8;

    typedef logic [FSR_STAT_W-1:0] fsr_stat_t;

    typedef struct packed {
        logic      act;
        fsr_stat_t hold;
    } fsr_state_t;
endpackage

// File: rtl/fsr_strobe_detect.sv
module fsr_strobe_detect (
    input  logic ce_n,
    input  logic oe_n,
    input  logic act_q,
    output logic active,
    output logic start
);
    always_comb begin
        active = !ce_n && !oe_n;
        start  = active && !act_q;
    end
endmodule

// File: rtl/fsr_status_select.sv
module fsr_status_select #(
    parameter int unsigned NUM_PART = 2,
    parameter int unsigned STAT_W   = 8,
    localparam int unsigned SEL_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
    input  logic [NUM_PART*STAT_W-1:0] live_flat,
    input  logic [SEL_W-1:0]           sel,
    output logic [STAT_W-1:0]          picked
);
    logic [STAT_W-1:0] slice [NUM_PART];

    for (genvar p = 0; p < NUM_PART; p++) begin : g_slice
        assign slice[p] = live_flat[p*STAT_W +: STAT_W];
    end

    always_comb begin
        picked = '0;
        for (int p = 0; p < NUM_PART; p++) begin
            if (SEL_W'(p) == sel) picked = slice[p];
        end
    end
endmodule

// File: rtl/fsr_bus_format.sv
module fsr_bus_format #(
    parameter int unsigned STAT_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              drive,
    input  logic [STAT_W-1:0] held,
    output logic [DATA_W-1:0] bus
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < STAT_W) begin : g_stat
            assign bus[b] = drive & held[b];
        end else begin : g_pad
            assign bus[b] = 1'b0;
        end
    end
endmodule

// File: rtl/flash_status_latch.sv
module flash_status_latch
    import fsr_pkg::*;
#(
    parameter int unsigned NUM_PART = 2,
    parameter int unsigned DATA_W   = 16,
    localparam int unsigned STAT_W  = FSR_STAT_W,
    localparam int unsigned SEL_W   = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_n,
    input  logic                       oe_n,
    input  logic [SEL_W-1:0]           part_sel,
    input  logic [NUM_PART*STAT_W-1:0] status_live,
    input  logic                       stat_mode,
    output logic [DATA_W-1:0]          dq_out,
    output logic                       dq_oe
);
    fsr_state_t st_d, st_q;
    logic       active, start;
    fsr_stat_t  picked;

    fsr_strobe_detect u_strobe (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .act_q  (st_q.act),
        .active (active),
        .start  (start)
    );

    fsr_status_select #(
        .NUM_PART (NUM_PART),
        .STAT_W   (STAT_W)
    ) u_select (
        .live_flat (status_live),
        .sel       (part_sel),
        .picked    (picked)
    );

    always_comb begin
        st_d     = st_q;
        st_d.act = active;
        if (start) st_d.hold = picked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_oe = st_q.act & stat_mode;

    fsr_bus_format #(
        .STAT_W (STAT_W),
        .DATA_W (DATA_W)
    ) u_format (
        .drive (dq_oe),
        .held  (st_q.hold),
        .bus   (dq_out)
    );
endmodule

// File: rtl/flash_status_latch_chk.sv
module flash_status_latch_chk #(
    parameter int unsigned NUM_PART = 2,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned STAT_W   = 8,
    parameter int unsigned SEL_W    = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ce_n,
    input logic                       oe_n,
    input logic [SEL_W-1:0]           part_sel,
    input logic [NUM_PART*STAT_W-1:0] status_live,
    input logic                       stat_mode,
    input logic [DATA_W-1:0]          dq_out,
    input logic                       dq_oe
);
    logic [STAT_W-1:0] sel_live;
    assign sel_live = status_live[part_sel*STAT_W +: STAT_W];

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_out[DATA_W-1:STAT_W] == '0);

    // R2
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> (dq_oe == stat_mode));

    // R2
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> !dq_oe);

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && $past(ce_n || oe_n)) |=>
            (!stat_mode || dq_out[STAT_W-1:0] == $past(sel_live)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    // R8
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_mode |-> (!dq_oe && dq_out == '0));
endmodule

bind flash_status_latch flash_status_latch_chk #(
    .NUM_PART (NUM_PART),
    .DATA_W   (DATA_W),
    .STAT_W   (STAT_W),
    .SEL_W    (SEL_W)
) u_chk (.*);

// File: tb/flash_status_latch_test.sv
module flash_status_latch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [0:0]  part_sel = 1'b0;
    logic [15:0] status_live = 16'h0000;
    logic        stat_mode = 1'b1;
    logic [15:0] dq_out;
    logic        dq_oe;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic        m_act = 1'b0;
    logic [7:0]  m_hold = 8'h00;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    flash_status_latch uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .part_sel    (part_sel),
        .status_live (status_live),
        .stat_mode   (stat_mode),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );

    function automatic logic [15:0] exp_bus(logic act, logic [7:0] h, logic md);
        return (act && md) ? {8'h00, h} : 16'h0000;
    endfunction

    task automatic check(string req);
        logic [15:0] eb;
        logic        eo;
        eo = m_act && stat_mode;
        eb = exp_bus(m_act, m_hold, stat_mode);
        n_vec++;
        if (dq_oe !== eo || dq_out !== eb) begin
            n_bad++;
            $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, dq_oe, dq_out, eo, eb);
        end
    endtask

    // drive at negedge, model the clock edge, compare at the next negedge
    task automatic step(logic c, logic o, logic s, logic [7:0] s0, logic [7:0] s1,
                        logic md, string req);
        logic act_now;
        ce_n = c; oe_n = o; part_sel = s; status_live = {s1, s0}; stat_mode = md;
        @(posedge clk);
        act_now = !c && !o;
        if (act_now && !m_act) m_hold = s ? s1 : s0;
        m_act = act_now;
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R1: outputs quiet under reset, even with strobes low
        ce_n = 1'b0; oe_n = 1'b0; status_live = 16'h5A3C;
        @(negedge clk);
        n_vec++;
        if (dq_oe !== 1'b0 || dq_out !== 16'h0000) begin
            n_bad++;
            $display("FAIL R1: oe=%0b dq=%h expected oe=0 dq=0000", dq_oe, dq_out);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b1;
        step(1, 1, 0, 8'h11, 8'h22, 1, "R1");

        // R2/R3: both fall together, partition 0 then 1
        step(0, 0, 0, 8'h81, 8'h42, 1, "R3");
        step(0, 0, 0, 8'h81, 8'h42, 1, "R2");
        step(1, 0, 0, 8'h81, 8'h42, 1, "R2");
        step(0, 0, 1, 8'h81, 8'h42, 1, "R3");
        step(1, 1, 1, 8'h81, 8'h42, 1, "R2");

        // R4: live status and select change while held, including on load edge
        step(0, 0, 0, 8'h07, 8'h70, 1, "R4");
        step(0, 0, 1, 8'h08, 8'h71, 1, "R4");
        step(0, 0, 1, 8'hFF, 8'hEE, 1, "R4");
        step(1, 1, 0, 8'h00, 8'h00, 1, "R4");

        // R6: ce falls first, status moves, oe falls later
        step(0, 1, 1, 8'h01, 8'h02, 1, "R6");
        step(0, 1, 1, 8'h01, 8'h03, 1, "R6");
        step(0, 0, 1, 8'h01, 8'h04, 1, "R6");
        step(0, 0, 1, 8'h01, 8'h05, 1, "R6");
        step(1, 1, 1, 8'h01, 8'h05, 1, "R6");
        // oe first, then ce
        step(1, 0, 0, 8'h10, 8'h00, 1, "R6");
        step(0, 0, 0, 8'h20, 8'h00, 1, "R6");
        step(1, 1, 0, 8'h30, 8'h00, 1, "R6");

        // R7: poll partition 1 until bit 7 (ready) set
        for (int k = 0; k < 4; k++) begin
            logic [7:0] sv;
            sv = (k == 3) ? 8'h80 : 8'h00;
            step(0, 0, 1, 8'h00, sv, 1, "R7");
            step(1, 0, 1, 8'h00, sv, 1, "R7");
        end
        n_vec++;
        if (m_hold[7] !== 1'b1) begin
            n_bad++;
            $display("FAIL R7: ready bit=%0b expected 1", m_hold[7]);
        end

        // R8: status mode off masks output, restored while held
        step(0, 0, 0, 8'h9C, 8'h00, 0, "R8");
        step(0, 0, 0, 8'h9C, 8'h00, 0, "R8");
        step(0, 0, 0, 8'h11, 8'h00, 1, "R8");
        step(1, 1, 0, 8'h11, 8'h00, 1, "R8");

        // R5/R4: random mix
        for (int i = 0; i < 3000; i++) begin
            logic c, o, s, md;
            logic [15:0] sl;
            c  = ($urandom % 4) == 0;
            o  = ($urandom % 4) == 0;
            s  = $urandom % 2;
            md = ($urandom % 8) != 0;
            sl = 16'($urandom);
            step(c, o, s, sl[7:0], sl[15:8], md, "R4");
            n_vec++;
            if (dq_out[15:8] !== 8'h00) begin
                n_bad++;
                $display("FAIL R5: upper=%h expected 00", dq_out[15:8]);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule